// File: doc/BRIEF.md
# Shift Key Hold Tracker

This block sits behind a keyboard scan-code receiver and reports, cycle by cycle, whether the left shift key, the right shift key, or either of them is currently held down. The receiver delivers one cleaned 8-bit scan code per key event, qualified by a one-cycle strobe. A press arrives as the key's make code. A release arrives as a release prefix byte (0xF0) followed by that key's make code.

A two-state machine tracks the release sequence. `ST_IDLE` is the normal state. `ST_RELEASE` is the break-pending state, entered after a prefix byte. There are five transitions:
- `ST_IDLE -> ST_RELEASE` on 0xF0.
- `ST_RELEASE -> ST_IDLE` on a shift make code, which clears that key's flag.
- `ST_RELEASE -> ST_IDLE` on any other non-prefix code, with no flag change.
- `ST_RELEASE -> ST_RELEASE` on a repeated 0xF0 or on the extended prefix 0xE0.
- `ST_IDLE -> ST_IDLE` on every other code. A shift make code on this transition sets that key's flag.

Each key has its own registered held flag, so releasing one shift key leaves the combined output asserted while the other is still down.

Top module: `shkey_tracker`

## Requirements
- R1: Synchronous reset clears both held flags and the shift output and puts the machine in `ST_IDLE`.
- R2: A valid code 0x12 received in `ST_IDLE` sets `left_held`.
- R3: A valid code 0x59 received in `ST_IDLE` sets `right_held`.
- R4: A valid 0xF0 followed by a valid 0x12 clears `left_held`. A valid 0xF0 followed by a valid 0x59 clears `right_held`.
- R5: `shift` always equals `left_held` OR `right_held`, so releasing one key while the other is held keeps `shift` high.
- R6: Outputs change only in the cycle after a cycle with `code_valid` high. Inputs without `code_valid` have no effect.
- R7: In `ST_RELEASE`, any code other than 0x12, 0x59, 0xF0 or 0xE0 returns the machine to `ST_IDLE` with both flags unchanged.
- R8: The extended prefix 0xE0 changes neither flags nor state in either state, so 0xF0, 0xE0, 0x12 still releases the left key.
- R9: Repeated make codes of a held shift key leave its flag set. Codes of other keys in `ST_IDLE` change no flag.
- R10: A second 0xF0 received in `ST_RELEASE` keeps the machine in `ST_RELEASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 8 | Scan code from the receiver |
| code_valid | input | 1 | One-cycle strobe qualifying `code` |
| shift | output | 1 | Registered OR of both held flags |
| left_held | output | 1 | Left shift key held |
| right_held | output | 1 | Right shift key held |

## Verification
A wrong state hides until the next shift make code arrives. If the machine has wrongly stayed in `ST_RELEASE`, that code clears a flag that should have been set, which shows one cycle later. If the machine has wrongly left `ST_RELEASE`, a release code sets the flag instead of clearing it. Flag or output mismatches appear on the first cycle after the offending valid code. The checks therefore follow every prefix pattern with a shift code and compare all three outputs each cycle.

// File: rtl/shkey_pkg.sv
package shkey_pkg;
    localparam int          KEY_W      = 8;
    localparam logic [7:0]  LEFT_MAKE  = 8'h12;
    localparam logic [7:0]  RIGHT_MAKE = 8'h59;
    localparam logic [7:0]  REL_PFX    = 8'hF0;
    localparam logic [7:0]  EXT_PFX    = 8'hE0;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_RELEASE = 1'b1
    } shk_state_t;

    typedef struct packed {
        logic is_left;
        logic is_right;
        logic is_rel;
        logic is_ext;
    } shk_class_t;
endpackage

// File: rtl/shkey_decode.sv
module shkey_decode
    import shkey_pkg::*;
#(
    parameter int              CODE_W = KEY_W,
    parameter logic [CODE_W-1:0] L_CODE = CODE_W'(LEFT_MAKE),
    parameter logic [CODE_W-1:0] R_CODE = CODE_W'(RIGHT_MAKE),
    parameter logic [CODE_W-1:0] P_CODE = CODE_W'(REL_PFX),
    parameter logic [CODE_W-1:0] E_CODE = CODE_W'(EXT_PFX)
) (
    input  logic [CODE_W-1:0] code,
    output shk_class_t        cls
);
    always_comb begin
        cls.is_left  = (code == L_CODE);
        cls.is_right = (code == R_CODE);
        cls.is_rel   = (code == P_CODE);
        cls.is_ext   = (code == E_CODE);
    end
endmodule

// File: rtl/shkey_fsm.sv
module shkey_fsm
    import shkey_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       code_valid,
    input  shk_class_t cls,
    output logic       rel_pend,
    output logic       set_l,
    output logic       clr_l,
    output logic       set_r,
    output logic       clr_r
);
    shk_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        set_l   = 1'b0;
        clr_l   = 1'b0;
        set_r   = 1'b0;
        clr_r   = 1'b0;
        if (code_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cls.is_rel) state_d = ST_RELEASE;
                    set_l = cls.is_left;
                    set_r = cls.is_right;
                end
                ST_RELEASE: begin
                    if (!cls.is_rel && !cls.is_ext) state_d = ST_IDLE;
                    clr_l = cls.is_left;
                    clr_r = cls.is_right;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign rel_pend = (state_q == ST_RELEASE);
endmodule

// File: rtl/shkey_flags.sv
module shkey_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic left_q,
    output logic right_q,
    output logic shift_q
);
    logic left_d, right_d;

    always_comb begin
        left_d  = left_q;
        right_d = right_q;
        if (set_l) left_d  = 1'b1;
        if (clr_l) left_d  = 1'b0;
        if (set_r) right_d = 1'b1;
        if (clr_r) right_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q  <= 1'b0;
            right_q <= 1'b0;
            shift_q <= 1'b0;
        end else begin
            left_q  <= left_d;
            right_q <= right_d;
            shift_q <= left_d | right_d;
        end
    end
endmodule

// File: rtl/shkey_tracker.sv
module shkey_tracker
    import shkey_pkg::*;
#(
    parameter int CODE_W = KEY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              code_valid,
    output logic              shift,
    output logic              left_held,
    output logic              right_held
);
    shk_class_t cls;
    logic rel_pend, set_l, clr_l, set_r, clr_r;

    shkey_decode #(.CODE_W(CODE_W)) u_dec (
        .code (code),
        .cls  (cls)
    );

    shkey_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .code_valid (code_valid),
        .cls        (cls),
        .rel_pend   (rel_pend),
        .set_l      (set_l),
        .clr_l      (clr_l),
        .set_r      (set_r),
        .clr_r      (clr_r)
    );

    shkey_flags u_flg (
        .clk     (clk),
        .rst     (rst),
        .set_l   (set_l),
        .clr_l   (clr_l),
        .set_r   (set_r),
        .clr_r   (clr_r),
        .left_q  (left_held),
        .right_q (right_held),
        .shift_q (shift)
    );
endmodule

// File: rtl/shkey_tracker_chk.sv
module shkey_tracker_chk
    import shkey_pkg::*;
#(
    parameter int CODE_W = KEY_W
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code,
    input logic              code_valid,
    input logic              shift,
    input logic              left_held,
    input logic              right_held,
    input logic              rel_pend
);
    localparam logic [CODE_W-1:0] LC = CODE_W'(LEFT_MAKE);
    localparam logic [CODE_W-1:0] RC = CODE_W'(RIGHT_MAKE);
    localparam logic [CODE_W-1:0] PC = CODE_W'(REL_PFX);
    localparam logic [CODE_W-1:0] EC = CODE_W'(EXT_PFX);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!shift && !left_held && !right_held && !rel_pend));

    // R2
    left_set_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !rel_pend && code == LC) |=> left_held);

    // R3
    right_set_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && !rel_pend && code == RC) |=> right_held);

    // R4
    left_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && rel_pend && code == LC) |=> (!left_held && !rel_pend));

    // R5
    shift_or_chk: assert property (@(posedge clk) disable iff (rst)
        shift == (left_held | right_held));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !code_valid |=> ($stable(left_held) && $stable(right_held) && $stable(shift)));

    // R7
    other_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && rel_pend && code != LC && code != RC && code != PC && code != EC)
        |=> (!rel_pend && $stable(left_held) && $stable(right_held)));

    // R8
    ext_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code == EC)
        |=> ($stable(rel_pend) && $stable(left_held) && $stable(right_held)));

    // R10
    pfx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (code_valid && code == PC) |=> rel_pend);
endmodule

bind shkey_tracker shkey_tracker_chk #(.CODE_W(CODE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .code       (code),
    .code_valid (code_valid),
    .shift      (shift),
    .left_held  (left_held),
    .right_held (right_held),
    .rel_pend   (rel_pend)
);

// File: tb/shkey_tracker_tb.sv
`timescale 1ns/1ps
module shkey_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] code = 8'h00;
    logic       code_valid = 1'b0;
    logic       shift, left_held, right_held;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench reference model
    bit m_rel = 0, m_l = 0, m_r = 0;

    always #2.5 clk = ~clk;

    shkey_tracker dut_i (
        .clk(clk), .rst(rst), .code(code), .code_valid(code_valid),
        .shift(shift), .left_held(left_held), .right_held(right_held)
    );

    function automatic void model_step(input bit v, input logic [7:0] c);
        if (!v) return;
        if (!m_rel) begin
            if (c == 8'hF0) m_rel = 1;
            else if (c == 8'h12) m_l = 1;
            else if (c == 8'h59) m_r = 1;
        end else begin
            if (c == 8'h12) begin m_l = 0; m_rel = 0; end
            else if (c == 8'h59) begin m_r = 0; m_rel = 0; end
            else if (c != 8'hF0 && c != 8'hE0) m_rel = 0;
        end
    endfunction

    task automatic check(input string tag, input bit el, input bit er);
        bit es;
        es = el | er;
        checks++;
        if (left_held !== el || right_held !== er || shift !== es) begin
            failures++;
            $display("FAIL %s: got L=%b R=%b S=%b expected L=%b R=%b S=%b",
                     tag, left_held, right_held, shift, el, er, es);
        end
    endtask

    // drive at negedge, check at following negedge against model
    task automatic step(input bit v, input logic [7:0] c, input string tag);
        code = c;
        code_valid = v;
        model_step(v, c);
        @(negedge clk);
        code_valid = 1'b0;
        check(tag, m_l, m_r);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        code_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_rel = 0; m_l = 0; m_r = 0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 0, 0);
        rst = 1'b0;

        step(1, 8'h12, "R2 left make");
        step(1, 8'h59, "R3 right make");
        step(1, 8'hF0, "R4 prefix");
        step(1, 8'h12, "R4 R5 left release other held");
        step(1, 8'hF0, "R4 prefix");
        step(1, 8'h59, "R4 right release");
        step(0, 8'h12, "R6 no valid left");
        step(0, 8'h12, "R6 no valid hold");
        step(1, 8'h12, "R9 left make");
        step(1, 8'h12, "R9 left repeat");
        step(1, 8'h1C, "R9 other key");
        step(1, 8'hF0, "R7 prefix");
        step(1, 8'h1C, "R7 other code aborts");
        step(1, 8'h59, "R7 right sets after abort");
        step(1, 8'hE0, "R8 ext in idle");
        step(1, 8'hF0, "R8 prefix");
        step(1, 8'hE0, "R8 ext in release");
        step(1, 8'h12, "R8 left release after ext");
        step(1, 8'hF0, "R10 prefix");
        step(1, 8'hF0, "R10 second prefix");
        step(1, 8'h59, "R10 right release");
        step(1, 8'h12, "R2 left again");
        do_reset();
        check("R1 reset mid-run", 0, 0);

        process::self().srandom(32'd1234);
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [7:0] c;
            sel = $urandom_range(0, 5);
            case (sel)
                0: c = 8'h12;
                1: c = 8'h59;
                2: c = 8'hF0;
                3: c = 8'hE0;
                default: c = 8'($urandom);
            endcase
            step($urandom_range(0, 3) != 0, c, "R5 R6 random");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule